// File: doc/BRIEF.md
# ECC SRAM Controller with Hard-Error Cache

This block sits between one requester and a synchronous word array. Each stored word is 32 data bits plus 7 check bits of an extended Hamming single-error-correct, double-error-detect code. Reads are checked and corrected. When a read finds a single-bit error, the controller writes the repaired word back into the array, reads the word again, and only then answers. The repaired word and its address are kept in a one-entry hard-error cache. A later read of that same address is answered from the cache, without touching the array. A cell that stays broken therefore cannot trap the requester in an endless repair-and-retry loop. A side effect is that such a read reports no new error.

Corrected errors feed a counter with a programmable threshold. The counter raises a sticky interrupt and records the failing address. Uncorrectable errors get their own sticky flag and address. Two test controls support error injection. The first lets a write replace only the stored check bits. The second turns checking off, so that writes change only data and reads return raw data.

Requests and responses both use valid/ready handshakes, with one transaction in flight at a time. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the accept edge of a read until its response has been consumed. A response stays on `rsp_*` with `rsp_valid` high, and does not change, until an edge where `rsp_ready` is high. Writes produce no response.

Top module: `ecc_hec_ctrl`

## Requirements
- R1: A normal write followed by a read of the same word returns the written data with `rsp_sec` and `rsp_ded` low. `rsp_valid` rises on the second edge counted from the accept edge.
- R2: Check bits [5:0] are Hamming parities over code positions 1..38. Data bits occupy the positions that are not powers of two, in ascending order. Check bit 6 is the parity over all data bits and check bits [5:0]. All-zero data therefore encodes to all-zero check bits. A single flipped data or check bit is corrected in the returned data, and `rsp_sec` is high.
- R3: On a single-bit error the controller spends three further cycles on write-back, re-read and respond. For such a read the response is valid on the fifth edge from the accept edge, and `req_ready` stays low throughout. The array then holds the repaired word.
- R4: A checked read whose address matches the valid cache entry is answered on the accept edge itself, with the cached data. It reports no error and does not advance the error counter.
- R5: Every single-bit error loads its address and repaired data into the cache, replacing the previous entry. An address that is already cached reports again only after an error elsewhere has displaced it.
- R6: A double-bit error returns the raw data with `rsp_ded` high. It sets `ded_err` and records `ded_addr`. It is neither cached nor written back, so reading the word again reports it again.
- R7: With `thr` at zero, a corrected error does not count, does not raise `sec_irq` and leaves `sec_addr` unchanged.
- R8: With a nonzero `thr`, every counted correction records its address in `sec_addr`. `sec_irq` rises on the correction that brings the count to `thr`.
- R9: A `stat_clr` pulse zeroes the count and clears `sec_irq` and `ded_err`.
- R10: A data write to the cached address also updates the cached data.
- R11: A write with `chk_wr_en` high replaces only the stored check bits, with `req_wdata[6:0]`. The stored data is left unchanged.
- R12: With `ecc_en` low, reads skip the cache and checking and return raw array data with no flags. Writes store data only and keep the old check bits.
- R13: A response held by low `rsp_ready` stays valid and stable, and no new request is accepted until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data (bits 6:0 are check bits when `chk_wr_en` is high) |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data |
| rsp_sec | output | 1 | Response carried a corrected single-bit error |
| rsp_ded | output | 1 | Response carried an uncorrectable error |
| ecc_en | input | 1 | Checking enable |
| chk_wr_en | input | 1 | Writes replace check bits only |
| thr | input | THR_W | Correction threshold, 0 disables counting |
| stat_clr | input | 1 | Clears count and sticky status |
| sec_irq | output | 1 | Sticky threshold interrupt |
| sec_addr | output | ADDR_W | Address of last counted correction |
| ded_err | output | 1 | Sticky uncorrectable-error flag |
| ded_addr | output | ADDR_W | Address of last uncorrectable error |

## Verification
The assertions assume that every checked read targets a word written earlier, so the decoder never sees unknown contents. They also assume that `thr`, `ecc_en` and `chk_wr_en` are changed only while no read is in flight. The bench builds every corrupted word from words written as zero: it then flips check bits with check-bit-only writes, or flips data bits with writes made while checking is off. Controls are changed only between transactions, and the response side is stalled in one dedicated scenario only.

// File: rtl/ecc_hec_pkg.sv
package ecc_hec_pkg;
  localparam int DATA_W = 32;
  localparam int PAR_W  = 6;
  localparam int CHK_W  = PAR_W + 1;
  localparam int POS_N  = DATA_W + PAR_W;

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WB, ST_RR, ST_RSP} st_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              sec;
    logic              ded;
  } dec_t;

  // Hamming parities over positions 1..POS_N, data in non-power-of-two slots
  function automatic logic [CHK_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [PAR_W-1:0] p;
    logic [4:0]       k;
    p = '0;
    k = '0;
    for (int pos = 1; pos <= POS_N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        p = p ^ (PAR_W'(pos) & {PAR_W{d[k]}});
        k = k + 5'd1;
      end
    end
    return {(^d) ^ (^p), p};
  endfunction

  function automatic dec_t ecc_decode(input logic [DATA_W-1:0] d,
                                      input logic [CHK_W-1:0]  c);
    dec_t             r;
    logic [CHK_W-1:0] re;
    logic [PAR_W-1:0] syn;
    logic             perr;
    logic [4:0]       k;
    re   = ecc_encode(d);
    syn  = re[PAR_W-1:0] ^ c[PAR_W-1:0];
    perr = (^d) ^ (^c);
    r.data = d;
    r.sec  = perr;
    r.ded  = !perr && (syn != '0);
    k = '0;
    for (int pos = 1; pos <= POS_N; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (perr && (PAR_W'(pos) == syn)) r.data[k] = ~d[k];
        k = k + 5'd1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc_hec_array.sv
module ecc_hec_array
  import ecc_hec_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk,
  input  logic              wr_dat_en,
  input  logic              wr_chk_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [CHK_W-1:0]  mem_c [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_dat_en) mem_d[wr_addr] <= wr_data;
    if (wr_chk_en) mem_c[wr_addr] <= wr_chk;
    if (rd_en) begin
      rd_data <= mem_d[rd_addr];
      rd_chk  <= mem_c[rd_addr];
    end
  end
endmodule

// File: rtl/ecc_hec_entry.sv
module ecc_hec_entry
  import ecc_hec_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              upd,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [DATA_W-1:0] upd_data
);
  logic              valid;
  logic [ADDR_W-1:0] tag;
  logic [DATA_W-1:0] data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      data  <= '0;
    end else if (ld) begin
      valid <= 1'b1;
      tag   <= ld_addr;
      data  <= ld_data;
    end else if (upd && valid && (upd_addr == tag)) begin
      data  <= upd_data;
    end
  end

  assign hit      = valid && (look_addr == tag);
  assign hit_data = data;

  // R5: a load replaces the whole entry
  p_load_replace_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (valid && tag == $past(ld_addr) && data == $past(ld_data)));

  // R10: a write to the held address refreshes the data
  p_write_refresh_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !ld && valid && upd_addr == tag) |=> (data == $past(upd_data)));
endmodule

// File: rtl/ecc_hec_track.sv
module ecc_hec_track #(
  parameter int ADDR_W = 6,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [THR_W-1:0]  thr,
  input  logic              sec_ev,
  input  logic              ded_ev,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              irq,
  output logic [ADDR_W-1:0] sec_addr,
  output logic              ded_flag,
  output logic [ADDR_W-1:0] ded_addr
);
  logic [THR_W-1:0] cnt;
  logic [THR_W-1:0] cnt_inc;
  logic             count_on;

  assign cnt_inc  = cnt + THR_W'(1);
  assign count_on = (thr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      irq      <= 1'b0;
      sec_addr <= '0;
      ded_flag <= 1'b0;
      ded_addr <= '0;
    end else if (clr) begin
      cnt      <= '0;
      irq      <= 1'b0;
      ded_flag <= 1'b0;
    end else begin
      if (sec_ev && count_on) begin
        if (cnt != '1) cnt <= cnt_inc;
        if (cnt_inc == thr) irq <= 1'b1;
        sec_addr <= ev_addr;
      end
      if (ded_ev) begin
        ded_flag <= 1'b1;
        ded_addr <= ev_addr;
      end
    end
  end

  // R7: zero threshold keeps the interrupt and capture quiet
  p_thr_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0 && !clr) |=> (!$rose(irq) && $stable(sec_addr) && $stable(cnt)));

  // R8: the interrupt only rises after a counted correction
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(sec_ev && count_on));

  // R9: clear empties the count and sticky flags
  p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !irq && !ded_flag));
endmodule

// File: rtl/ecc_hec_ctrl.sv
module ecc_hec_ctrl
  import ecc_hec_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_sec,
  output logic              rsp_ded,
  input  logic              ecc_en,
  input  logic              chk_wr_en,
  input  logic [THR_W-1:0]  thr,
  input  logic              stat_clr,
  output logic              sec_irq,
  output logic [ADDR_W-1:0] sec_addr,
  output logic              ded_err,
  output logic [ADDR_W-1:0] ded_addr
);
  st_e               st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] fix_q;
  logic              ecc_q;
  logic              rsp_pend;

  logic              fire, rd_fire, wr_fire, use_cache;
  logic              c_hit;
  logic [DATA_W-1:0] c_data;
  logic              arr_re, arr_wd, arr_wc;
  logic [ADDR_W-1:0] arr_raddr, arr_waddr;
  logic [DATA_W-1:0] arr_rdata, arr_wdata;
  logic [CHK_W-1:0]  arr_rchk, arr_wchk;
  dec_t              dec;
  logic              sec_ev, ded_ev;

  assign req_ready = (st == ST_IDLE) && !rsp_pend;
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && !req_we;
  assign wr_fire   = fire && req_we;
  assign use_cache = rd_fire && ecc_en && c_hit;

  assign arr_re    = (rd_fire && !use_cache) || (st == ST_RR);
  assign arr_raddr = (st == ST_RR) ? addr_q : req_addr;
  assign arr_wd    = (wr_fire && !chk_wr_en) || (st == ST_WB);
  assign arr_wc    = (wr_fire && (chk_wr_en || ecc_en)) || (st == ST_WB);
  assign arr_waddr = (st == ST_WB) ? addr_q : req_addr;
  assign arr_wdata = (st == ST_WB) ? fix_q : req_wdata;

  always_comb begin
    if (st == ST_WB)     arr_wchk = ecc_encode(fix_q);
    else if (chk_wr_en)  arr_wchk = req_wdata[CHK_W-1:0];
    else                 arr_wchk = ecc_encode(req_wdata);
  end

  assign dec    = ecc_decode(arr_rdata, arr_rchk);
  assign sec_ev = (st == ST_RD) && ecc_q && dec.sec;
  assign ded_ev = (st == ST_RD) && ecc_q && dec.ded;

  ecc_hec_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rd_en(arr_re), .rd_addr(arr_raddr),
    .rd_data(arr_rdata), .rd_chk(arr_rchk),
    .wr_dat_en(arr_wd), .wr_chk_en(arr_wc), .wr_addr(arr_waddr),
    .wr_data(arr_wdata), .wr_chk(arr_wchk)
  );

  ecc_hec_entry #(.ADDR_W(ADDR_W)) u_entry (
    .clk(clk), .rst_n(rst_n), .look_addr(req_addr),
    .hit(c_hit), .hit_data(c_data),
    .ld(sec_ev), .ld_addr(addr_q), .ld_data(dec.data),
    .upd(wr_fire && !chk_wr_en), .upd_addr(req_addr), .upd_data(req_wdata)
  );

  ecc_hec_track #(.ADDR_W(ADDR_W), .THR_W(THR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(stat_clr), .thr(thr),
    .sec_ev(sec_ev), .ded_ev(ded_ev), .ev_addr(addr_q),
    .irq(sec_irq), .sec_addr(sec_addr), .ded_flag(ded_err), .ded_addr(ded_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      fix_q     <= '0;
      ecc_q     <= 1'b0;
      rsp_pend  <= 1'b0;
      rsp_rdata <= '0;
      rsp_sec   <= 1'b0;
      rsp_ded   <= 1'b0;
    end else begin
      if (rsp_pend && rsp_ready) rsp_pend <= 1'b0;
      unique case (st)
        ST_IDLE: if (rd_fire) begin
          addr_q <= req_addr;
          ecc_q  <= ecc_en;
          if (use_cache) begin
            rsp_rdata <= c_data;
            rsp_sec   <= 1'b0;
            rsp_ded   <= 1'b0;
            rsp_pend  <= 1'b1;
          end else begin
            st <= ST_RD;
          end
        end
        ST_RD: if (sec_ev) begin
          fix_q <= dec.data;
          st    <= ST_WB;
        end else begin
          rsp_rdata <= ecc_q ? dec.data : arr_rdata;
          rsp_sec   <= 1'b0;
          rsp_ded   <= ded_ev;
          rsp_pend  <= 1'b1;
          st        <= ST_IDLE;
        end
        ST_WB:  st <= ST_RR;
        ST_RR:  st <= ST_RSP;
        ST_RSP: begin
          rsp_rdata <= fix_q;
          rsp_sec   <= 1'b1;
          rsp_ded   <= 1'b0;
          rsp_pend  <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = rsp_pend;

  // R3: correction path holds off requests for three more cycles
  p_sec_sequence_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_ev |=> (!req_ready ##1 !req_ready ##1 !req_ready ##1 (rsp_valid && rsp_sec)));

  // R4: a cache hit answers on the accept edge without error
  p_hit_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && ecc_en && c_hit) |=> (rsp_valid && !rsp_sec && !rsp_ded));

  // R6: an uncorrectable word is answered directly with its flag
  p_ded_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ded_ev |=> (rsp_valid && rsp_ded && !rsp_sec && st == ST_IDLE));

  // R13: a stalled response does not move
  p_rsp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)
                                   && $stable(rsp_sec) && $stable(rsp_ded)));
endmodule

// File: tb/ecc_hec_ctrl_bench.sv
`timescale 1ns/1ps
module ecc_hec_ctrl_bench;
  localparam int AW = 6;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid, rsp_sec, rsp_ded;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_rdata;
  logic          ecc_en = 1'b1, chk_wr_en = 1'b0, stat_clr = 1'b0;
  logic [TW-1:0] thr = 4'd1;
  logic          sec_irq, ded_err;
  logic [AW-1:0] sec_addr, ded_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ecc_hec_ctrl #(.ADDR_W(AW), .THR_W(TW)) u_ecc_hec_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_sec(rsp_sec), .rsp_ded(rsp_ded), .ecc_en(ecc_en), .chk_wr_en(chk_wr_en),
    .thr(thr), .stat_clr(stat_clr), .sec_irq(sec_irq), .sec_addr(sec_addr),
    .ded_err(ded_err), .ded_addr(ded_addr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input bit cb);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; chk_wr_en = cb;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; chk_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d,
                    output logic s, output logic e, output int lat, output bit rlow);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; rlow = 1'b1;
    while (!rsp_valid && lat < 20) begin
      if (req_ready) rlow = 1'b0;
      @(negedge clk);
      lat++;
    end
    d = rsp_rdata; s = rsp_sec; e = rsp_ded;
  endtask

  task automatic clear_status();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R13", "ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", 32'(rsp_valid), 32'd0);
    chk(!sec_irq && !ded_err, "R9", "status after reset", {sec_irq, ded_err}, 32'd0);
  endtask

  task automatic t_roundtrip_r1();
    logic [31:0] d; logic s, e; int lat; bit rl;
    wr(6'd3, 32'hDEADBEEF, 1'b0);
    wr(6'd4, 32'h12345678, 1'b0);
    rd(6'd3, d, s, e, lat, rl);
    chk(d == 32'hDEADBEEF && !s && !e, "R1", "read word 3", d, 32'hDEADBEEF);
    chk(lat == 2, "R1", "array read latency", lat, 2);
    rd(6'd4, d, s, e, lat, rl);
    chk(d == 32'h12345678 && !s && !e, "R1", "read word 4", d, 32'h12345678);
  endtask

  task automatic t_sec_check_bit_r2();
    logic [31:0] d; logic s, e; int lat; bit rl;
    wr(6'd5, 32'h0, 1'b0);
    wr(6'd5, 32'h1, 1'b1);
    rd(6'd5, d, s, e, lat, rl);
    chk(d == 32'h0 && s && !e, "R2", "check bit flip corrected", {d[29:0], s, e}, 32'h2);
    chk(lat == 5 && rl, "R3", "correction latency, ready low", lat, 5);
    chk(sec_irq && sec_addr == 6'd5, "R8", "thr=1 irq and address", {sec_irq, 25'd0, sec_addr}, {1'b1, 25'd0, 6'd5});
    clear_status();
    chk(!sec_irq, "R9", "irq cleared", 32'(sec_irq), 32'd0);
  endtask

  task automatic t_cache_hit_r4();
    logic [31:0] d; logic s, e; int lat; bit rl;
    wr(6'd5, 32'h1, 1'b1);
    rd(6'd5, d, s, e, lat, rl);
    chk(d == 32'h0 && !s && !e && lat == 1, "R4", "hit bypasses corrupted word", {d[23:0], lat[7:0]}, 32'h1);
    chk(!sec_irq, "R4", "hit raises no interrupt", 32'(sec_irq), 32'd0);
  endtask

  task automatic t_replace_r5();
    logic [31:0] d; logic s, e; int lat; bit rl;
    wr(6'd6, 32'h0, 1'b0);
    @(negedge clk); ecc_en = 1'b0;
    wr(6'd6, 32'h10, 1'b0);
    @(negedge clk); ecc_en = 1'b1;
    rd(6'd6, d, s, e, lat, rl);
    chk(d == 32'h0 && s && lat == 5, "R2", "data bit flip corrected", d, 32'h0);
    chk(sec_irq && sec_addr == 6'd6, "R8", "address 6 captured", 32'(sec_addr), 32'd6);
    clear_status();
    rd(6'd5, d, s, e, lat, rl);
    chk(d == 32'h0 && s && lat == 5, "R5", "displaced address reports again", {31'd0, s}, 32'd1);
    chk(sec_irq && sec_addr == 6'd5, "R5", "address 5 captured again", 32'(sec_addr), 32'd5);
    clear_status();
    rd(6'd6, d, s, e, lat, rl);
    chk(d == 32'h0 && !s && lat == 2, "R3", "written-back word reads clean", {d[23:0], lat[7:0]}, 32'h2);
  endtask

  task automatic t_ded_r6();
    logic [31:0] d; logic s, e; int lat; bit rl;
    wr(6'd7, 32'h0, 1'b0);
    @(negedge clk); ecc_en = 1'b0;
    wr(6'd7, 32'h3, 1'b0);
    @(negedge clk); ecc_en = 1'b1;
    rd(6'd7, d, s, e, lat, rl);
    chk(d == 32'h3 && e && !s && lat == 2, "R6", "double error raw data", d, 32'h3);
    chk(ded_err && ded_addr == 6'd7 && !sec_irq, "R6", "sticky double flag", 32'(ded_addr), 32'd7);
    rd(6'd7, d, s, e, lat, rl);
    chk(e && lat == 2, "R6", "not cached nor repaired", {31'd0, e}, 32'd1);
    clear_status();
    chk(!ded_err, "R9", "double flag cleared", 32'(ded_err), 32'd0);
  endtask

  task automatic t_thr_zero_r7();
    logic [31:0] d; logic s, e; int lat; bit rl;
    logic [AW-1:0] prev;
    prev = sec_addr;
    wr(6'd8, 32'h0, 1'b0);
    wr(6'd8, 32'h40, 1'b1);
    @(negedge clk); thr = 4'd0;
    rd(6'd8, d, s, e, lat, rl);
    chk(d == 32'h0 && s, "R7", "correction still applied", d, 32'h0);
    chk(!sec_irq && sec_addr == prev, "R7", "no count with zero threshold", 32'(sec_addr), 32'(prev));
    @(negedge clk); thr = 4'd1;
  endtask

  task automatic t_thr_two_r8();
    logic [31:0] d; logic s, e; int lat; bit rl;
    clear_status();
    @(negedge clk); thr = 4'd2;
    wr(6'd9, 32'h0, 1'b0);  wr(6'd9, 32'h2, 1'b1);
    wr(6'd10, 32'h0, 1'b0); wr(6'd10, 32'h4, 1'b1);
    rd(6'd9, d, s, e, lat, rl);
    chk(s && !sec_irq, "R8", "first of two corrections", 32'(sec_irq), 32'd0);
    rd(6'd9, d, s, e, lat, rl);
    rd(6'd9, d, s, e, lat, rl);
    chk(!s && lat == 1 && !sec_irq, "R4", "hits leave count alone", 32'(sec_irq), 32'd0);
    rd(6'd10, d, s, e, lat, rl);
    chk(s && sec_irq && sec_addr == 6'd10, "R8", "second correction fires", {sec_irq, 25'd0, sec_addr}, {1'b1, 25'd0, 6'd10});
    clear_status();
    @(negedge clk); thr = 4'd1;
  endtask

  task automatic t_write_cached_r10();
    logic [31:0] d; logic s, e; int lat; bit rl;
    wr(6'd10, 32'hCAFE0001, 1'b0);
    rd(6'd10, d, s, e, lat, rl);
    chk(d == 32'hCAFE0001 && !s && lat == 1, "R10", "cached data refreshed", d, 32'hCAFE0001);
  endtask

  task automatic t_chk_only_r11();
    logic [31:0] d; logic s, e; int lat; bit rl;
    wr(6'd11, 32'hA5A5A5A5, 1'b0);
    wr(6'd11, 32'hFFFFFF80, 1'b1);
    @(negedge clk); ecc_en = 1'b0;
    rd(6'd11, d, s, e, lat, rl);
    @(negedge clk); ecc_en = 1'b1;
    chk(d == 32'hA5A5A5A5, "R11", "data kept on check-bit write", d, 32'hA5A5A5A5);
  endtask

  task automatic t_bypass_r12();
    logic [31:0] d; logic s, e; int lat; bit rl;
    wr(6'd12, 32'h0, 1'b0);
    @(negedge clk); ecc_en = 1'b0;
    wr(6'd12, 32'h1, 1'b0);
    rd(6'd12, d, s, e, lat, rl);
    chk(d == 32'h1 && !s && !e && lat == 2, "R12", "raw read unchecked", d, 32'h1);
    rd(6'd10, d, s, e, lat, rl);
    chk(d == 32'hCAFE0001 && lat == 2, "R12", "cache skipped when off", lat, 2);
    @(negedge clk); ecc_en = 1'b1;
    rd(6'd12, d, s, e, lat, rl);
    chk(d == 32'h0 && s, "R12", "old check bits kept", d, 32'h0);
    clear_status();
  endtask

  task automatic t_backpressure_r13();
    logic [31:0] d0;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_we = 1'b0; req_addr = 6'd3;
    @(negedge clk);
    req_addr = 6'd4;
    while (!rsp_valid) @(negedge clk);
    d0 = rsp_rdata;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == d0, "R13", "stalled response stable", rsp_rdata, d0);
      chk(!req_ready, "R13", "no accept while pending", 32'(req_ready), 32'd0);
    end
    chk(d0 == 32'hDEADBEEF, "R13", "stalled data", d0, 32'hDEADBEEF);
    req_valid = 1'b0;
    @(negedge clk); rsp_ready = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R13", "response taken", {rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_roundtrip_r1();
    t_sec_check_bit_r2();
    t_cache_hit_r4();
    t_replace_r5();
    t_ded_r6();
    t_thr_zero_r7();
    t_thr_two_r8();
    t_write_cached_r10();
    t_chk_only_r11();
    t_bypass_r12();
    t_backpressure_r13();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule